// File: doc/BRIEF.md
# Two-Tier Port Arbiter with Weighted Sharing

This block decides which of up to four host ports may use a shared memory controller next. Each port raises a request with a direction (read or write) and a burst length. Each port also carries three settings: a kind that says whether it may read, write or both, an absolute priority level, and a relative weight. The arbiter first keeps only the requests whose direction the port's kind allows. Among those it keeps only the ports at the highest priority level present. Within that tied group it shares grants in proportion to the weights, using a credit counter per port.

A grant is held for the whole burst of the winning request. After the burst there is one idle cycle, and then arbitration runs again. A request whose direction the port's kind forbids never wins. It sets a per-port error flag that stays set until reset. The grant comes out both as a one-hot vector and as a port index, together with the direction of the granted request.

Top module: `prio_weight_arbiter`

## Requirements
- R1: After reset, gnt_valid, gnt_onehot and err_dir are all zero, and every port's credit counter is zero.
- R2: A port's kind is encoded as 00 = bidirectional, 01 = read-only, 10 = write-only, and 11 behaves as bidirectional. A write request (req_write=1) from a read-only port, or a read request from a write-only port, is ignored and never granted.
- R3: A forbidden request on port i sets err_dir[i] on the next clock edge. The bit then stays set, whatever the inputs do, until reset.
- R4: A grant always goes to an eligible port whose cfg_prio is the largest among all eligible ports. A larger number means a higher priority.
- R5: Within the tied group, the port with nonzero weight and the largest effective credit wins, and ties go to the lowest index. The winner's credit drops by one.
- R6: When the tied group holds at least one nonzero-weight port and all such ports have zero credit, every port's credit reloads to its weight at that decision. With weights 3 and 1 and both ports requesting, this gives grants in a 3:1 ratio: port A, A, A, then B.
- R7: A port with weight 0 is granted only when no tied port with nonzero weight is requesting. If the whole tied group has weight 0, the lowest index wins.
- R8: Weight values above 32 behave exactly as 32.
- R9: Arbitration happens in a cycle with no grant active and at least one eligible request. The grant appears after the next clock edge and lasts req_len+1 cycles, using the winner's req_len at the decision. It is followed by at least one cycle without a grant. Request inputs seen during a burst do not change the grant.
- R10: While gnt_valid is 1, gnt_onehot has exactly bit gnt_idx set and gnt_write equals the req_write of the winning request at the decision. While gnt_valid is 0, gnt_onehot is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_kind | input | NPORTS x 2 | Per-port direction kind |
| cfg_prio | input | NPORTS x PRIO_W | Per-port absolute priority, larger wins |
| cfg_weight | input | NPORTS x WGT_W | Per-port relative weight, 0 to 32 |
| req_valid | input | NPORTS | Per-port request present |
| req_write | input | NPORTS | Per-port request direction, 1 = write |
| req_len | input | NPORTS x LEN_W | Per-port burst length minus one |
| gnt_valid | output | 1 | A grant is active |
| gnt_onehot | output | NPORTS | One-hot granted port |
| gnt_idx | output | IDX_W | Index of the granted port |
| gnt_write | output | 1 | Direction of the granted request |
| err_dir | output | NPORTS | Sticky per-port forbidden-direction flag |

## Verification
The credit counters are the only state hidden from the ports, and a wrong count shows up at the grant outputs within one refill round of the tied group. A lost decrement or a missed reload changes the winner order at the next decision, which is at most a few bursts later. A miscounted burst shows as a grant edge that comes one cycle early or late. A forbidden request that leaks through shows as a grant on the very next cycle. The bench therefore compares every output on every cycle against a model of the requirements, and adds directed runs for the 3:1 ratio, the clamp and the zero-weight cases.

// File: rtl/arb_pkg.sv
package arb_pkg;

   typedef enum logic [1:0] {
      KIND_BIDIR   = 2'b00,
      KIND_RD_ONLY = 2'b01,
      KIND_WR_ONLY = 2'b10,
      KIND_SPARE   = 2'b11
   } port_kind_e;

   // Direction legality of a request for a given port kind.
   function automatic logic dir_ok(input logic [1:0] kind, input logic is_wr);
      case (port_kind_e'(kind))
         KIND_RD_ONLY: dir_ok = !is_wr;
         KIND_WR_ONLY: dir_ok = is_wr;
         default:      dir_ok = 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/arb_port_filter.sv
module arb_port_filter
   import arb_pkg::*;
#(
   parameter int NPORTS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPORTS-1:0][1:0] cfg_kind,
   input  logic [NPORTS-1:0]      req_valid,
   input  logic [NPORTS-1:0]      req_write,
   output logic [NPORTS-1:0]      elig,
   output logic [NPORTS-1:0]      err_dir
);

   for (genvar i = 0; i < NPORTS; i++) begin : g_port
      logic bad;
      assign bad     = req_valid[i] && !dir_ok(cfg_kind[i], req_write[i]);
      assign elig[i] = req_valid[i] && !bad;

      always_ff @(posedge clk) begin
         if (!rst_n)   err_dir[i] <= 1'b0;
         else if (bad) err_dir[i] <= 1'b1;
      end

      // R3: once raised, the flag never drops without reset
      a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         err_dir[i] |=> err_dir[i]);
   end

endmodule

// File: rtl/arb_prio_select.sv
module arb_prio_select #(
   parameter int NPORTS = 4,
   parameter int PRIO_W = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NPORTS-1:0]           elig,
   input  logic [NPORTS-1:0][PRIO_W-1:0] cfg_prio,
   output logic [NPORTS-1:0]           tie_mask,
   output logic                        any_elig
);

   logic [PRIO_W-1:0] top_lvl;

   always_comb begin
      top_lvl = '0;
      for (int i = 0; i < NPORTS; i++)
         if (elig[i] && cfg_prio[i] > top_lvl) top_lvl = cfg_prio[i];
      for (int i = 0; i < NPORTS; i++)
         tie_mask[i] = elig[i] && (cfg_prio[i] == top_lvl);
   end

   assign any_elig = |elig;

   for (genvar i = 0; i < NPORTS; i++) begin : g_chk_i
      // R4: a tied port is eligible
      a_r4_tied_elig: assert property (@(posedge clk) disable iff (!rst_n)
         tie_mask[i] |-> elig[i]);
      for (genvar j = 0; j < NPORTS; j++) begin : g_chk_j
         // R4: no eligible port outranks a tied port
         a_r4_top_prio: assert property (@(posedge clk) disable iff (!rst_n)
            (tie_mask[i] && elig[j]) |-> (cfg_prio[j] <= cfg_prio[i]));
      end
   end

endmodule

// File: rtl/arb_weight_pick.sv
module arb_weight_pick #(
   parameter int NPORTS  = 4,
   parameter int WGT_W   = 6,
   parameter int WGT_MAX = 32,
   localparam int IDX_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NPORTS-1:0]            tie_mask,
   input  logic [NPORTS-1:0][WGT_W-1:0] cfg_weight,
   input  logic                         take,
   output logic [IDX_W-1:0]             win_idx,
   output logic                         win_valid
);

   logic [NPORTS-1:0][WGT_W-1:0] wclamp, cred_q, eff, cred_d;
   logic [NPORTS-1:0]            tied_nz, live;
   logic                         refill, found, got_first;
   logic [IDX_W-1:0]             best, first;
   logic [WGT_W-1:0]             best_eff;

   always_comb begin
      for (int i = 0; i < NPORTS; i++) begin
         wclamp[i]  = (cfg_weight[i] > WGT_W'(WGT_MAX)) ? WGT_W'(WGT_MAX) : cfg_weight[i];
         tied_nz[i] = tie_mask[i] && (wclamp[i] != '0);
         live[i]    = tied_nz[i] && (cred_q[i] != '0);
      end
      refill = (|tied_nz) && !(|live);

      found    = 1'b0;
      best     = '0;
      best_eff = '0;
      for (int i = 0; i < NPORTS; i++) begin
         eff[i] = refill ? wclamp[i] : cred_q[i];
         if (tied_nz[i] && eff[i] != '0 && (!found || eff[i] > best_eff)) begin
            found    = 1'b1;
            best     = IDX_W'(i);
            best_eff = eff[i];
         end
      end

      got_first = 1'b0;
      first     = '0;
      for (int i = 0; i < NPORTS; i++)
         if (!got_first && tie_mask[i]) begin
            got_first = 1'b1;
            first     = IDX_W'(i);
         end

      for (int i = 0; i < NPORTS; i++)
         cred_d[i] = eff[i] - ((found && best == IDX_W'(i)) ? WGT_W'(1) : WGT_W'(0));
   end

   assign win_idx   = found ? best : first;
   assign win_valid = |tie_mask;

   always_ff @(posedge clk) begin
      if (!rst_n)    cred_q <= '0;
      else if (take) cred_q <= cred_d;
   end

   // R7: a zero-weight winner implies no nonzero-weight tied requester
   a_r7_zero_weight: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && wclamp[win_idx] == '0) |-> (tied_nz == '0));
   // R5: the chosen port belongs to the tied group
   a_r5_win_tied: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> tie_mask[win_idx]);

endmodule

// File: rtl/prio_weight_arbiter.sv
module prio_weight_arbiter #(
   parameter int NPORTS    = 4,
   parameter int PRIO_W    = 3,
   parameter int WGT_W     = 6,
   parameter int WGT_MAX   = 32,
   parameter int MAX_BURST = 16,
   localparam int LEN_W    = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1,
   localparam int IDX_W    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NPORTS-1:0][1:0]        cfg_kind,
   input  logic [NPORTS-1:0][PRIO_W-1:0] cfg_prio,
   input  logic [NPORTS-1:0][WGT_W-1:0]  cfg_weight,
   input  logic [NPORTS-1:0]             req_valid,
   input  logic [NPORTS-1:0]             req_write,
   input  logic [NPORTS-1:0][LEN_W-1:0]  req_len,
   output logic                          gnt_valid,
   output logic [NPORTS-1:0]             gnt_onehot,
   output logic [IDX_W-1:0]              gnt_idx,
   output logic                          gnt_write,
   output logic [NPORTS-1:0]             err_dir
);

   // Four shared read and four shared write buffers bound the port count.
   if (NPORTS < 1 || NPORTS > 4) begin : g_bad_nports
      $error("NPORTS must be 1 to 4");
   end
   if (WGT_MAX < 1 || WGT_MAX >= (1 << WGT_W)) begin : g_bad_wgt
      $error("WGT_MAX must fit in WGT_W bits");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("PRIO_W must be positive");
   end

   logic [NPORTS-1:0] elig, tie_mask;
   logic              any_elig, win_valid, take;
   logic [IDX_W-1:0]  win_idx;
   logic [LEN_W-1:0]  beat_cnt;

   arb_port_filter #(.NPORTS(NPORTS)) u_filter (
      .clk(clk), .rst_n(rst_n), .cfg_kind(cfg_kind),
      .req_valid(req_valid), .req_write(req_write),
      .elig(elig), .err_dir(err_dir));

   arb_prio_select #(.NPORTS(NPORTS), .PRIO_W(PRIO_W)) u_prio (
      .clk(clk), .rst_n(rst_n), .elig(elig), .cfg_prio(cfg_prio),
      .tie_mask(tie_mask), .any_elig(any_elig));

   arb_weight_pick #(.NPORTS(NPORTS), .WGT_W(WGT_W), .WGT_MAX(WGT_MAX)) u_weight (
      .clk(clk), .rst_n(rst_n), .tie_mask(tie_mask), .cfg_weight(cfg_weight),
      .take(take), .win_idx(win_idx), .win_valid(win_valid));

   assign take = !gnt_valid && any_elig;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_valid <= 1'b0;
         gnt_idx   <= '0;
         gnt_write <= 1'b0;
         beat_cnt  <= '0;
      end else if (take) begin
         gnt_valid <= 1'b1;
         gnt_idx   <= win_idx;
         gnt_write <= req_write[win_idx];
         beat_cnt  <= req_len[win_idx];
      end else if (gnt_valid) begin
         if (beat_cnt == '0) gnt_valid <= 1'b0;
         else                beat_cnt  <= beat_cnt - 1'b1;
      end
   end

   always_comb begin
      gnt_onehot = '0;
      if (gnt_valid) gnt_onehot[gnt_idx] = 1'b1;
   end

   // R9: mid-burst, the grant and its port stay put
   a_r9_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && beat_cnt != '0) |=> (gnt_valid && $stable(gnt_idx)));
   // R9: the last beat is followed by a grant-free cycle
   a_r9_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && beat_cnt == '0) |=> !gnt_valid);
   // R9: a decision needs a candidate from the weight stage
   a_r9_take_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> win_valid);

endmodule

// File: tb/sim_prio_weight_arbiter.sv
module sim_prio_weight_arbiter;

   localparam int N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0][1:0] cfg_kind;
   logic [N-1:0][2:0] cfg_prio;
   logic [N-1:0][5:0] cfg_weight;
   logic [N-1:0]      req_valid, req_write;
   logic [N-1:0][3:0] req_len;
   logic              gnt_valid, gnt_write;
   logic [N-1:0]      gnt_onehot, err_dir;
   logic [1:0]        gnt_idx;

   always #2 clk = ~clk;

   prio_weight_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .cfg_kind(cfg_kind), .cfg_prio(cfg_prio),
      .cfg_weight(cfg_weight), .req_valid(req_valid), .req_write(req_write),
      .req_len(req_len), .gnt_valid(gnt_valid), .gnt_onehot(gnt_onehot),
      .gnt_idx(gnt_idx), .gnt_write(gnt_write), .err_dir(err_dir));

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // model of the requirements
   bit m_gv, m_wr;
   int m_idx, m_cnt;
   int m_cred[N];
   bit [N-1:0] m_err;
   bit last_gv;
   int hist[64];
   int hcount;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit allowed(input int kind, input bit wr);
      if (kind == 1) return !wr;
      if (kind == 2) return wr;
      return 1'b1;
   endfunction

   task automatic model_reset();
      m_gv = 0; m_wr = 0; m_idx = 0; m_cnt = 0; m_err = '0;
      for (int i = 0; i < N; i++) m_cred[i] = 0;
   endtask

   task automatic model_step();
      bit elig[N];
      bit any;
      int top, wc[N], ec[N], win, best_ec;
      bit tied[N], tnz[N], anynz, anylive, refill, found;
      any = 0;
      for (int i = 0; i < N; i++) begin
         elig[i] = req_valid[i] && allowed(int'(cfg_kind[i]), req_write[i]);
         if (req_valid[i] && !elig[i]) m_err[i] = 1'b1;
         any |= elig[i];
      end
      if (!m_gv && any) begin
         top = 0;
         for (int i = 0; i < N; i++) if (elig[i] && int'(cfg_prio[i]) > top) top = int'(cfg_prio[i]);
         anynz = 0; anylive = 0;
         for (int i = 0; i < N; i++) begin
            tied[i] = elig[i] && int'(cfg_prio[i]) == top;
            wc[i]   = (int'(cfg_weight[i]) > 32) ? 32 : int'(cfg_weight[i]);
            tnz[i]  = tied[i] && wc[i] > 0;
            anynz  |= tnz[i];
            anylive |= tnz[i] && m_cred[i] > 0;
         end
         refill = anynz && !anylive;
         found = 0; win = 0; best_ec = 0;
         for (int i = 0; i < N; i++) begin
            ec[i] = refill ? wc[i] : m_cred[i];
            if (tnz[i] && ec[i] > 0 && (!found || ec[i] > best_ec)) begin
               found = 1; win = i; best_ec = ec[i];
            end
         end
         if (!found)
            for (int i = N - 1; i >= 0; i--) if (tied[i]) win = i;
         if (refill) for (int i = 0; i < N; i++) m_cred[i] = wc[i];
         if (found) m_cred[win] = m_cred[win] - 1;
         m_gv = 1; m_idx = win; m_wr = req_write[win]; m_cnt = int'(req_len[win]);
      end else if (m_gv) begin
         if (m_cnt == 0) m_gv = 0;
         else m_cnt--;
      end
   endtask

   task automatic check_outputs(input string ctx);
      chk(ctx, "gnt_valid", int'(gnt_valid), int'(m_gv));
      chk("R10", "gnt_onehot", int'(gnt_onehot), m_gv ? (1 << m_idx) : 0);
      if (m_gv) begin
         chk(ctx, "gnt_idx", int'(gnt_idx), m_idx);
         chk("R10", "gnt_write", int'(gnt_write), int'(m_wr));
      end
      chk("R3", "err_dir", int'(err_dir), int'(m_err));
   endtask

   task automatic tick(input string ctx);
      model_step();
      @(negedge clk);
      check_outputs(ctx);
      if (gnt_valid && !last_gv && hcount < 64) begin
         hist[hcount] = int'(gnt_idx);
         hcount++;
      end
      last_gv = gnt_valid;
   endtask

   task automatic clear_inputs();
      cfg_kind = '0; cfg_prio = '0; cfg_weight = '0;
      req_valid = '0; req_write = '0; req_len = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      clear_inputs();
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      last_gv = 0;
      hcount = 0;
   endtask

   function automatic int count_of(input int p);
      int c = 0;
      for (int k = 0; k < hcount; k++) if (hist[k] == p) c++;
      return c;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      int seed_v;
      int len_count;
      seed_v = int'($urandom(32'd20240611));
      clear_inputs();
      model_reset();

      // R1: reset state
      do_reset();
      @(negedge clk);
      chk("R1", "gnt_valid after reset", int'(gnt_valid), 0);
      chk("R1", "gnt_onehot after reset", int'(gnt_onehot), 0);
      chk("R1", "err_dir after reset", int'(err_dir), 0);
      model_step();

      // R6 / R5: weights 3 and 1 tied, both always requesting
      do_reset();
      cfg_weight[0] = 6'd3; cfg_weight[1] = 6'd1;
      cfg_prio[0] = 3'd2;   cfg_prio[1] = 3'd2;
      req_valid = 4'b0011;
      while (hcount < 16) tick("R6");
      chk("R6", "grants to weight-3 port", count_of(0), 12);
      chk("R6", "grants to weight-1 port", count_of(1), 4);
      chk("R5", "fourth grant goes to weight-1 port", hist[3], 1);
      chk("R5", "first grant goes to weight-3 port", hist[0], 0);

      // R4: higher priority always wins
      do_reset();
      cfg_prio[0] = 3'd3; cfg_weight[0] = 6'd32;
      cfg_prio[2] = 3'd5; cfg_weight[2] = 6'd1;
      req_valid = 4'b0101;
      while (hcount < 6) tick("R4");
      chk("R4", "grants to lower-priority port", count_of(0), 0);

      // R7: zero weight starves while a weighted peer requests
      do_reset();
      cfg_weight[0] = 6'd0; cfg_weight[1] = 6'd2;
      req_valid = 4'b0011;
      while (hcount < 6) tick("R7");
      chk("R7", "grants to zero-weight port", count_of(0), 0);
      req_valid = 4'b0001;
      while (hcount < 8) tick("R7");
      chk("R7", "zero-weight port alone", hist[7], 0);
      // R7: all-zero tie picks lowest index
      req_valid = 4'b1100;
      while (hcount < 10) tick("R7");
      chk("R7", "all-zero tie lowest index", hist[9], 2);

      // R8: 40 behaves as 32, so ports alternate
      do_reset();
      cfg_weight[0] = 6'd32; cfg_weight[1] = 6'd40;
      req_valid = 4'b0011;
      while (hcount < 4) tick("R8");
      chk("R8", "clamp order 0", hist[0], 0);
      chk("R8", "clamp order 1", hist[1], 1);
      chk("R8", "clamp order 2", hist[2], 0);
      chk("R8", "clamp order 3", hist[3], 1);

      // R2 / R3: forbidden directions
      do_reset();
      cfg_kind[1] = 2'b01; cfg_kind[2] = 2'b10; cfg_weight[1] = 6'd4; cfg_weight[2] = 6'd4;
      req_valid = 4'b0110; req_write = 4'b0010;
      for (int k = 0; k < 6; k++) tick("R2");
      chk("R2", "forbidden requests granted", hcount, 0);
      chk("R3", "flags raised", int'(err_dir), 6);
      req_valid = '0;
      for (int k = 0; k < 4; k++) tick("R3");
      chk("R3", "flags held", int'(err_dir), 6);
      req_valid = 4'b0010; req_write = 4'b0000;
      for (int k = 0; k < 2; k++) tick("R2");
      chk("R2", "allowed read on read-only port granted", hist[0], 1);

      // R9: burst length 6 on port 3, other requests ignored meanwhile
      do_reset();
      cfg_weight[3] = 6'd1; req_len[3] = 4'd5; req_valid = 4'b1000; req_write = 4'b1000;
      tick("R9");
      req_valid = 4'b0111; req_len = '0;
      len_count = 0;
      for (int k = 0; k < 8; k++) begin
         if (gnt_valid && gnt_idx == 2'd3) len_count++;
         tick("R9");
      end
      chk("R9", "burst cycles", len_count, 6);

      // random phase
      do_reset();
      for (int c = 0; c < 4000; c++) begin
         if (c % 250 == 0)
            for (int i = 0; i < N; i++) begin
               cfg_kind[i]   = 2'($urandom_range(0, 3));
               cfg_prio[i]   = 3'($urandom_range(0, 3));
               cfg_weight[i] = 6'($urandom_range(0, 40));
            end
         req_valid = 4'($urandom);
         req_write = 4'($urandom);
         for (int i = 0; i < N; i++) req_len[i] = 4'($urandom_range(0, 3));
         tick("R5");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule